// File: doc/BRIEF.md
# Keyed Indexed Configuration Register File

This block is a byte-wide configuration space for a system controller, reached through two I/O addresses on a simple synchronous bus. A write to the index address selects one of 256 register slots. A read or write at the data address then reaches the selected slot. Only a fixed set of slots holds storage. Every other slot discards writes and reads back as zero.

Changes are guarded by a key slot at index 0x03. That slot can be written at any time. Every other stored slot accepts data only while the key slot holds 0xC5. Writing any other value to the key locks the space again. Before storage, each accepted byte is filtered through a per-slot mask, so reserved bits always read back as zero.

A strap input marks a processor that keeps its own registers in part of the same index range. While that strap is set, data reads at index 0x20 and at indices 0xC0 and above return 0xFF. The full stored image is exported to the rest of the controller, together with three decoded enables. Each accepted write produces a one-cycle update strobe that carries the index written, so downstream decoders know when to recompute.

Top module: `keyed_cfg_space`

## Requirements
- R1: After reset, slot 0x3C holds 0x03, slot 0x3D holds 0x01 and slot 0x40 holds 0x03. Every other slot holds 0x00, and all three enables are low.
- R2: Slot 0x03 (the key) accepts any write at any time. Every other stored slot accepts a write only while the key holds 0xC5. Writes made while locked leave the stored image unchanged.
- R3: An accepted write is visible in the exported image (byte i at bits i*8+7..i*8) and in data-port reads from the following cycle on.
- R4: The stored slots are 0x03, 0x10–0x17, 0x19–0x1C, 0x1E, 0x20–0x22, 0x25–0x2B, 0x30–0x3D, 0x3F and 0x40–0x44. A write to any other index is ignored, and reads of such an index return 0x00.
- R5: Written bytes are ANDed with a per-slot mask before storage: 0x14 with 0xBF, 0x15 with 0xF1, 0x1E with 0x40, 0x22 with 0xFD, 0x2B with 0xBF, 0x36 with 0xE5, 0x37 with 0xEF, 0x3D with 0x07 and 0x40 with 0x3F. All other stored slots keep all eight bits.
- R6: `cache_int_en` follows bit 0 of slot 0x16, `cache_ext_en` follows bit 1 of slot 0x16, and `fast_a20_en` follows bit 4 of slot 0x29.
- R7: A write to address 0x22 loads the index, with no lock check. A read at any address other than 0x23 returns 0xFF. `io_rdata` is 0x00 whenever `io_rd` is low. Read data is valid in the same cycle as `io_rd`.
- R8: While `cpu_alt_mode` is high, data-port reads at index 0x20 or at any index from 0xC0 upward return 0xFF. The strap does not affect writes.
- R9: Each accepted data write raises `upd_pulse` for exactly the next cycle, with `upd_index` equal to the index that was written. Index loads and rejected writes raise no strobe.
- R10: When `io_rd` and `io_wr` are both high at the data address in the same cycle, the read returns the value stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | I/O address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data, same cycle as `io_rd` |
| cpu_alt_mode | input | 1 | Strap that blanks indices owned by the processor |
| cfg_image | output | NREG*8 | Stored slots, byte i at bits i*8+7..i*8 |
| cache_int_en | output | 1 | Internal cache enable |
| cache_ext_en | output | 1 | External cache enable |
| fast_a20_en | output | 1 | Enable for the fast gate-A20 / reset port |
| upd_pulse | output | 1 | One-cycle strobe after an accepted write |
| upd_index | output | 8 | Index written, valid with `upd_pulse` |

## Verification
A data-port read and a data-port write can arrive in the same cycle at the same slot. In that case the combinational read path has to return the old contents while the register stage captures the new ones. The bench provokes this by asserting both strobes in one cycle. The scoreboard expects the pre-write byte on `io_rdata` and an update strobe on the next cycle, and a follow-up read must return the new masked value. A second overlap is the key write against the lock check: a write that relocks the space is itself accepted and strobed, and the very next write to a normal slot must raise no strobe.

// File: rtl/kcs_pkg.sv
package kcs_pkg;

    localparam int BYTE_W = 8;

    localparam logic [7:0] KEY_INDEX  = 8'h03;
    localparam logic [7:0] KEY_VALUE  = 8'hC5;
    localparam logic [7:0] CACHE_IDX  = 8'h16;
    localparam logic [7:0] SYSCLK_IDX = 8'h29;
    localparam logic [7:0] BLANK_IDX  = 8'h20;
    localparam logic [7:0] BLANK_FROM = 8'hC0;

    typedef struct packed {
        logic       known;
        logic [7:0] mask;
    } wr_rule_t;

    // Storage presence and write mask of each index
    function automatic wr_rule_t rule_of(input logic [7:0] idx);
        wr_rule_t r;
        r.known = 1'b1;
        r.mask  = 8'hFF;
        unique case (idx)
            8'h14, 8'h2B: r.mask = 8'hBF;
            8'h15:        r.mask = 8'hF1;
            8'h1E:        r.mask = 8'h40;
            8'h22:        r.mask = 8'hFD;
            8'h36:        r.mask = 8'hE5;
            8'h37:        r.mask = 8'hEF;
            8'h3D:        r.mask = 8'h07;
            8'h40:        r.mask = 8'h3F;
            8'h03, 8'h10, 8'h11, 8'h12, 8'h13, 8'h16, 8'h17,
            8'h19, 8'h1A, 8'h1B, 8'h1C, 8'h20, 8'h21,
            8'h25, 8'h26, 8'h27, 8'h28, 8'h29, 8'h2A,
            8'h30, 8'h31, 8'h32, 8'h33, 8'h34, 8'h35,
            8'h38, 8'h39, 8'h3A, 8'h3B, 8'h3C, 8'h3F,
            8'h41, 8'h42, 8'h43, 8'h44: r.mask = 8'hFF;
            default: begin
                r.known = 1'b0;
                r.mask  = 8'h00;
            end
        endcase
        return r;
    endfunction

    function automatic logic [7:0] reset_value(input logic [7:0] idx);
        unique case (idx)
            8'h3C:   return 8'h03;
            8'h3D:   return 8'h01;
            8'h40:   return 8'h03;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/kcs_port_decode.sv
module kcs_port_decode #(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] IDX_PORT = 16'h0022,
    parameter logic [ADDR_W-1:0] DAT_PORT = 16'h0023
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic              idx_load,
    output logic              dat_write,
    output logic              dat_read
);
    logic hit_idx, hit_dat;

    always_comb begin
        hit_idx   = (io_addr == IDX_PORT);
        hit_dat   = (io_addr == DAT_PORT);
        idx_load  = io_wr && hit_idx;
        dat_write = io_wr && hit_dat;
        dat_read  = io_rd && hit_dat;
    end
endmodule

// File: rtl/kcs_write_policy.sv
module kcs_write_policy
    import kcs_pkg::*;
#(
    parameter int NREG = 72
) (
    input  logic       dat_write,
    input  logic [7:0] cur_idx,
    input  logic [7:0] wdata,
    input  logic [7:0] key_byte,
    output logic       accept,
    output logic [7:0] store_data
);
    wr_rule_t rule;
    logic     in_range;
    logic     unlocked;

    always_comb begin
        rule       = rule_of(cur_idx);
        in_range   = int'(cur_idx) < NREG;
        unlocked   = (key_byte == KEY_VALUE) || (cur_idx == KEY_INDEX);
        accept     = dat_write && rule.known && in_range && unlocked;
        store_data = wdata & rule.mask;
    end
endmodule

// File: rtl/kcs_store.sv
module kcs_store
    import kcs_pkg::*;
#(
    parameter int NREG = 72
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   idx_load,
    input  logic [7:0]             io_wdata,
    input  logic                   accept,
    input  logic [7:0]             store_data,
    output logic [7:0]             cur_idx,
    output logic [NREG-1:0][7:0]   regs,
    output logic                   upd,
    output logic [7:0]             upd_idx
);
    localparam int IW = $clog2(NREG);

    typedef struct packed {
        logic [7:0]           idx;
        logic [NREG-1:0][7:0] regs;
        logic                 upd;
        logic [7:0]           upd_idx;
    } st_t;

    st_t s_d, s_q, rst_st;
    logic [NREG-1:0][7:0] rst_img;

    for (genvar g = 0; g < NREG; g++) begin : g_rst
        assign rst_img[g] = reset_value(8'(g));
    end

    always_comb begin
        rst_st         = '0;
        rst_st.regs    = rst_img;

        s_d            = s_q;
        s_d.upd        = 1'b0;
        if (idx_load) begin
            s_d.idx = io_wdata;
        end
        if (accept) begin
            s_d.regs[s_q.idx[IW-1:0]] = store_data;
            s_d.upd                   = 1'b1;
            s_d.upd_idx               = s_q.idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= rst_st;
        else        s_q <= s_d;
    end

    assign cur_idx = s_q.idx;
    assign regs    = s_q.regs;
    assign upd     = s_q.upd;
    assign upd_idx = s_q.upd_idx;

    AST_REGS_HOLD_WITHOUT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(s_q.regs)); // R2
    AST_ACCEPT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> s_q.regs[$past(s_q.idx[IW-1:0])] == $past(store_data)); // R3
endmodule

// File: rtl/kcs_read_mux.sv
module kcs_read_mux
    import kcs_pkg::*;
#(
    parameter int NREG = 72
) (
    input  logic                 io_rd,
    input  logic                 dat_read,
    input  logic                 cpu_alt_mode,
    input  logic [7:0]           cur_idx,
    input  logic [NREG-1:0][7:0] regs,
    output logic [7:0]           rdata
);
    localparam int IW = $clog2(NREG);

    logic blanked, in_range;

    always_comb begin
        blanked  = cpu_alt_mode && ((cur_idx == BLANK_IDX) || (cur_idx >= BLANK_FROM));
        in_range = int'(cur_idx) < NREG;
        if (!io_rd)          rdata = 8'h00;
        else if (!dat_read)  rdata = 8'hFF;
        else if (blanked)    rdata = 8'hFF;
        else if (in_range)   rdata = regs[cur_idx[IW-1:0]];
        else                 rdata = 8'h00;
    end
endmodule

// File: rtl/keyed_cfg_space.sv
module keyed_cfg_space
    import kcs_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                NREG     = 72,
    parameter logic [ADDR_W-1:0] IDX_PORT = 16'h0022,
    parameter logic [ADDR_W-1:0] DAT_PORT = 16'h0023
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    io_addr,
    input  logic [7:0]           io_wdata,
    input  logic                 io_wr,
    input  logic                 io_rd,
    output logic [7:0]           io_rdata,
    input  logic                 cpu_alt_mode,
    output logic [NREG*8-1:0]    cfg_image,
    output logic                 cache_int_en,
    output logic                 cache_ext_en,
    output logic                 fast_a20_en,
    output logic                 upd_pulse,
    output logic [7:0]           upd_index
);
    localparam int KEY_LSB  = int'(KEY_INDEX) * BYTE_W;
    localparam int CACH_LSB = int'(CACHE_IDX) * BYTE_W;
    localparam int SCLK_LSB = int'(SYSCLK_IDX) * BYTE_W;
    localparam int MISC_LSB = 8'h3D * BYTE_W;

    logic                 idx_load, dat_write, dat_read;
    logic                 accept;
    logic [7:0]           store_data;
    logic [7:0]           cur_idx;
    logic [NREG-1:0][7:0] regs;

    kcs_port_decode #(
        .ADDR_W(ADDR_W), .IDX_PORT(IDX_PORT), .DAT_PORT(DAT_PORT)
    ) u_dec (
        .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .idx_load(idx_load), .dat_write(dat_write), .dat_read(dat_read)
    );

    kcs_write_policy #(.NREG(NREG)) u_pol (
        .dat_write(dat_write), .cur_idx(cur_idx), .wdata(io_wdata),
        .key_byte(regs[KEY_INDEX]), .accept(accept), .store_data(store_data)
    );

    kcs_store #(.NREG(NREG)) u_st (
        .clk(clk), .rst_n(rst_n), .idx_load(idx_load), .io_wdata(io_wdata),
        .accept(accept), .store_data(store_data), .cur_idx(cur_idx),
        .regs(regs), .upd(upd_pulse), .upd_idx(upd_index)
    );

    kcs_read_mux #(.NREG(NREG)) u_rd (
        .io_rd(io_rd), .dat_read(dat_read), .cpu_alt_mode(cpu_alt_mode),
        .cur_idx(cur_idx), .regs(regs), .rdata(io_rdata)
    );

    assign cfg_image    = regs;
    assign cache_int_en = cfg_image[CACH_LSB + 0];
    assign cache_ext_en = cfg_image[CACH_LSB + 1];
    assign fast_a20_en  = cfg_image[SCLK_LSB + 4];

    AST_STROBE_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pulse && upd_index != KEY_INDEX) |-> $past(cfg_image[KEY_LSB +: 8]) == KEY_VALUE); // R2
    AST_MISC_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pulse && upd_index == 8'h3D) |-> cfg_image[MISC_LSB + 3 +: 5] == 5'd0); // R5
    AST_OTHER_PORT_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr != DAT_PORT) |-> io_rdata == 8'hFF); // R7
    AST_STROBE_FROM_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |-> ($past(io_wr) && $past(io_addr) == DAT_PORT)); // R9
endmodule

// File: tb/keyed_cfg_space_test.sv
module keyed_cfg_space_test;
    localparam int NREG = 72;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       io_addr = '0;
    logic [7:0]        io_wdata = '0;
    logic              io_wr = 1'b0;
    logic              io_rd = 1'b0;
    logic [7:0]        io_rdata;
    logic              cpu_alt_mode = 1'b0;
    logic [NREG*8-1:0] cfg_image;
    logic              cache_int_en, cache_ext_en, fast_a20_en;
    logic              upd_pulse;
    logic [7:0]        upd_index;

    int compared = 0;
    int mismatched = 0;

    logic [7:0] rq_exp[$];
    string      rq_tag[$];
    logic [7:0] pq_idx[$];
    string      pq_tag[$];

    always #5 clk = ~clk;

    keyed_cfg_space #(.NREG(NREG)) uut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
        .cpu_alt_mode(cpu_alt_mode), .cfg_image(cfg_image),
        .cache_int_en(cache_int_en), .cache_ext_en(cache_ext_en),
        .fast_a20_en(fast_a20_en), .upd_pulse(upd_pulse), .upd_index(upd_index)
    );

    function automatic logic [7:0] img(input int i);
        return cfg_image[i*8 +: 8];
    endfunction

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
        end
    endtask

    // Monitor: compares reads and update strobes against the queues
    always @(negedge clk) begin
        if (rst_n) begin
            if (io_rd) begin
                compared++;
                if (rq_exp.size() == 0) begin
                    mismatched++;
                    $display("FAIL R7 unexpected read actual=%02h expected=none", io_rdata);
                end else begin
                    automatic logic [7:0] e = rq_exp.pop_front();
                    automatic string      t = rq_tag.pop_front();
                    if (io_rdata !== e) begin
                        mismatched++;
                        $display("FAIL %s read actual=%02h expected=%02h", t, io_rdata, e);
                    end
                end
            end
            if (upd_pulse) begin
                compared++;
                if (pq_idx.size() == 0) begin
                    mismatched++;
                    $display("FAIL R9 unexpected strobe actual=%02h expected=none", upd_index);
                end else begin
                    automatic logic [7:0] e = pq_idx.pop_front();
                    automatic string      t = pq_tag.pop_front();
                    if (upd_index !== e) begin
                        mismatched++;
                        $display("FAIL %s strobe index actual=%02h expected=%02h", t, upd_index, e);
                    end
                end
            end
        end
    end

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d,
                             input bit pulse, input logic [7:0] pidx, input string tag);
        @(posedge clk); #1;
        if (pulse) begin
            pq_idx.push_back(pidx);
            pq_tag.push_back(tag);
        end
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(posedge clk); #1;
        io_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        rq_exp.push_back(exp);
        rq_tag.push_back(tag);
        io_addr = a; io_rd = 1'b1;
        @(posedge clk); #1;
        io_rd = 1'b0;
    endtask

    task automatic set_index(input logic [7:0] idx);
        bus_write(16'h0022, idx, 1'b0, 8'h00, "R7");
    endtask

    task automatic reg_write(input logic [7:0] idx, input logic [7:0] d,
                             input bit pulse, input string tag);
        set_index(idx);
        bus_write(16'h0023, d, pulse, idx, tag);
    endtask

    task automatic reg_read(input logic [7:0] idx, input logic [7:0] exp, input string tag);
        set_index(idx);
        bus_read(16'h0023, exp, tag);
    endtask

    logic [7:0] m_idx [9] = '{8'h14, 8'h15, 8'h1E, 8'h22, 8'h2B, 8'h36, 8'h37, 8'h3D, 8'h40};
    logic [7:0] m_val [9] = '{8'hBF, 8'hF1, 8'h40, 8'hFD, 8'hBF, 8'hE5, 8'hEF, 8'h07, 8'h3F};

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #4;
        // R1: reset image
        check(img(8'h3C), 8'h03, "R1 slot3C");
        check(img(8'h3D), 8'h01, "R1 slot3D");
        check(img(8'h40), 8'h03, "R1 slot40");
        check(img(8'h10), 8'h00, "R1 slot10");
        check(img(8'h03), 8'h00, "R1 key");
        check({5'd0, cache_int_en, cache_ext_en, fast_a20_en}, 8'h00, "R1 enables");
        check(io_rdata, 8'h00, "R7 idle rdata");

        // R2: locked writes are dropped
        reg_write(8'h10, 8'h5A, 1'b0, "R2");
        reg_read(8'h10, 8'h00, "R2 locked write");
        check(img(8'h10), 8'h00, "R2 image locked");

        // R7: reads at other addresses
        bus_read(16'h0022, 8'hFF, "R7 index port read");
        bus_read(16'h0080, 8'hFF, "R7 foreign port read");

        // R2: unlock via key
        reg_write(8'h03, 8'hC5, 1'b1, "R2 key");
        reg_read(8'h03, 8'hC5, "R2 key readback");

        // R3: accepted write
        reg_write(8'h10, 8'h5A, 1'b1, "R3");
        check(img(8'h10), 8'h5A, "R3 image");
        reg_read(8'h10, 8'h5A, "R3 readback");

        // R5: masks
        for (int k = 0; k < 9; k++) begin
            reg_write(m_idx[k], 8'hFF, 1'b1, "R5");
            reg_read(m_idx[k], m_val[k], "R5 mask");
        end
        reg_write(8'h3A, 8'hFF, 1'b1, "R5 full");
        reg_read(8'h3A, 8'hFF, "R5 unmasked slot");

        // R4: slots without storage
        reg_write(8'h18, 8'h77, 1'b0, "R4");
        reg_read(8'h18, 8'h00, "R4 undefined 18");
        check(img(8'h18), 8'h00, "R4 image 18");
        reg_write(8'h3E, 8'h33, 1'b0, "R4");
        reg_read(8'h3E, 8'h00, "R4 undefined 3E");
        reg_write(8'h50, 8'h44, 1'b0, "R4");
        reg_read(8'h50, 8'h00, "R4 above range");

        // R6: decoded enables
        reg_write(8'h16, 8'h03, 1'b1, "R6");
        check({6'd0, cache_ext_en, cache_int_en}, 8'h03, "R6 both caches");
        reg_write(8'h16, 8'h02, 1'b1, "R6");
        check({6'd0, cache_ext_en, cache_int_en}, 8'h02, "R6 external only");
        reg_write(8'h29, 8'h10, 1'b1, "R6");
        check({7'd0, fast_a20_en}, 8'h01, "R6 a20 on");
        reg_write(8'h29, 8'hEF, 1'b1, "R6");
        check({7'd0, fast_a20_en}, 8'h00, "R6 a20 off");

        // R8: blanking strap
        cpu_alt_mode = 1'b1;
        reg_write(8'h20, 8'hAB, 1'b1, "R8 write under strap");
        reg_read(8'h20, 8'hFF, "R8 blank 20");
        reg_read(8'hC0, 8'hFF, "R8 blank C0");
        reg_read(8'hFF, 8'hFF, "R8 blank FF");
        reg_write(8'h21, 8'h11, 1'b1, "R8");
        reg_read(8'h21, 8'h11, "R8 not blanked 21");
        cpu_alt_mode = 1'b0;
        reg_read(8'h20, 8'hAB, "R8 strap off");
        reg_read(8'hC0, 8'h00, "R8 strap off C0");

        // R10: read and write together
        reg_write(8'h11, 8'h22, 1'b1, "R10 prep");
        set_index(8'h11);
        @(posedge clk); #1;
        rq_exp.push_back(8'h22); rq_tag.push_back("R10 old value");
        pq_idx.push_back(8'h11); pq_tag.push_back("R10 strobe");
        io_addr = 16'h0023; io_wdata = 8'h99; io_wr = 1'b1; io_rd = 1'b1;
        @(posedge clk); #1;
        io_wr = 1'b0; io_rd = 1'b0;
        bus_read(16'h0023, 8'h99, "R10 new value");

        // R2/R9: relock is accepted, next write is not
        reg_write(8'h03, 8'h00, 1'b1, "R9 relock");
        reg_write(8'h10, 8'h00, 1'b0, "R9");
        reg_read(8'h10, 8'h5A, "R2 relocked");

        repeat (3) @(posedge clk);
        #1;
        compared++;
        if (pq_idx.size() != 0) begin
            mismatched++;
            $display("FAIL R9 missing strobes actual=%0d expected=0", pq_idx.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #2_000_000;
        compared++;
        mismatched++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule